// File: doc/BRIEF.md
# Run-Length Transition Density Checker

This block sits behind a deserializer and looks at the parallel receive word that arrives on each clock. It measures how long the line has stayed at one level. A run is a stretch of identical bits, either all zeros or all ones. The run is followed bit by bit through each word, and it continues across word boundaries. When the current run reaches a programmable threshold, the block reports a transition density violation.

The threshold has a hard floor of half the bus width, and an optional scaling select can multiply it. A one-cycle pulse marks each word in which the limit was reached. A sticky flag records that at least one violation has happened since software last cleared it. The current run length is also brought out, so the receiver can watch it. Words are only accepted while the data-valid strobe is high.

Top module: `rl_density_mon`

## Requirements
- R1: While reset is held and right after it, `run_len` is 0 and both `viol_pulse` and `viol_sticky` are 0. Reset also discards the previous bit, so the first bit received after reset always starts a run of length 1.
- R2: Bit 0 of `in_data` is the earliest bit received. A bit equal to the bit before it adds one to the run, and a bit that differs restarts the run at 1. After an accepted word, `run_len` holds the run length at bit W-1.
- R3: The previous bit and the run count carry over into the next accepted word, so a run can span several words.
- R4: `viol_pulse` is 1 in the cycle after an accepted word if the run count at any bit position of that word is greater than or equal to the effective threshold. Otherwise it is 0.
- R5: A programmed `thresh` below W/2 is treated as W/2.
- R6: The effective threshold is the clamped threshold shifted left by `scale_sel`: 0 gives x1, 1 gives x2, 2 gives x4 and 3 gives x8.
- R7: The run count saturates at 2^CW-1 and does not wrap.
- R8: In a cycle with `in_valid` low, the run count and the previous bit are unchanged and `viol_pulse` is 0 in the following cycle.
- R9: `viol_sticky` is set together with `viol_pulse` and stays set until `sticky_clr` is sampled high in a cycle that has no new violation. If a violation and a clear arrive at the same edge, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The word on `in_data` is accepted at this edge |
| in_data | input | W | Parallel receive word; bit 0 is the earliest bit |
| thresh | input | TW | Programmed run-length threshold |
| scale_sel | input | 2 | Threshold multiplier select |
| sticky_clr | input | 1 | Clears the sticky violation flag |
| viol_pulse | output | 1 | A violation occurred in the last accepted word |
| viol_sticky | output | 1 | Sticky violation flag |
| run_len | output | CW | Current run length |

## Verification
The bench builds the block with W=8, CW=6 and TW=6. With these values the floor of 4, the scaled thresholds up to 32, and counter saturation at 63 can all be reached in a handful of words. The narrow bus makes it easy to construct runs that cross word boundaries by hand. It also makes it easy to build runs that stop exactly one bit short of the threshold, or land exactly on it.

// File: rtl/rl_density_mon.sv
module rl_density_mon #(
  parameter int W  = 20,
  parameter int CW = 16,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  in_data,
  input  logic [TW-1:0] thresh,
  input  logic [1:0]    scale_sel,
  input  logic          sticky_clr,
  output logic          viol_pulse,
  output logic          viol_sticky,
  output logic [CW-1:0] run_len
);

  localparam int EW   = TW + 3;
  localparam int CMPW = (CW > EW) ? CW : EW;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};
  localparam logic [TW-1:0] HALF = TW'(W / 2);

  logic          last_q, known_q;
  logic [CW-1:0] run_q;
  logic [CW-1:0] run_n;
  logic          last_n, hit;
  logic [TW-1:0] thr_fl;
  logic [EW-1:0] eff;

  assign thr_fl = (thresh < HALF) ? HALF : thresh;
  assign eff    = {3'b000, thr_fl} << scale_sel;

  always_comb begin
    logic k;
    run_n  = run_q;
    last_n = last_q;
    k      = known_q;
    hit    = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (k && (in_data[i] == last_n))
        run_n = (run_n == CMAX) ? run_n : run_n + 1'b1;
      else
        run_n = CW'(1);
      last_n = in_data[i];
      k      = 1'b1;
      if (CMPW'(run_n) >= CMPW'(eff)) hit = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q       <= '0;
      last_q      <= 1'b0;
      known_q     <= 1'b0;
      viol_pulse  <= 1'b0;
      viol_sticky <= 1'b0;
    end else begin
      viol_pulse <= in_valid && hit;
      if (in_valid) begin
        run_q   <= run_n;
        last_q  <= last_n;
        known_q <= 1'b1;
      end
      if (in_valid && hit)  viol_sticky <= 1'b1;
      else if (sticky_clr)  viol_sticky <= 1'b0;
    end
  end

  assign run_len = run_q;

  assert_pulse_sets_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse |-> viol_sticky);

  assert_sticky_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_sticky && !sticky_clr) |=> viol_sticky);

  assert_clear_works_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_clr && !in_valid) |=> !viol_sticky);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!viol_pulse && $stable(run_len)));

  assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && known_q && run_len == CMAX && in_data == {W{last_q}}) |=> run_len == CMAX);

  assert_run_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> run_len != '0);

endmodule

// File: tb/rl_density_mon_tb.sv
module rl_density_mon_tb;
  localparam int  W = 8, CW = 6, TW = 6;
  localparam time CLK_T = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [W-1:0]  in_data = '0;
  logic [TW-1:0] thresh = '0;
  logic [1:0]    scale_sel = '0;
  logic          sticky_clr = 1'b0;
  logic          viol_pulse, viol_sticky;
  logic [CW-1:0] run_len;

  int total = 0, bad = 0;

  rl_density_mon #(.W(W), .CW(CW), .TW(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .thresh(thresh), .scale_sel(scale_sel), .sticky_clr(sticky_clr),
    .viol_pulse(viol_pulse), .viol_sticky(viol_sticky), .run_len(run_len));

  always #(CLK_T/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect3(input string req, input int r, input int p, input int s);
    chk({req, " run_len"}, run_len, r);
    chk({req, " viol_pulse"}, viol_pulse, p);
    chk({req, " viol_sticky"}, viol_sticky, s);
  endtask

  task automatic send(input logic [W-1:0] d, input logic clr);
    in_valid = 1'b1; in_data = d; sticky_clr = clr;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0; sticky_clr = 1'b0;
  endtask

  task automatic idle(input logic clr);
    in_valid = 1'b0; sticky_clr = clr;
    @(posedge clk); @(negedge clk);
    sticky_clr = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    expect3("R1 in reset", 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    expect3("R1 after reset", 0, 0, 0);
  endtask

  task automatic t_runs_carry();
    thresh = 6; scale_sel = 0;
    send(8'hF0, 0);  expect3("R2 first word", 4, 0, 0);
    send(8'h03, 0);  expect3("R3 R4 run across words", 6, 1, 1);
  endtask

  task automatic t_idle_clear();
    idle(0);  expect3("R8 idle", 6, 0, 1);
    idle(1);  expect3("R9 clear", 6, 0, 0);
  endtask

  task automatic t_clamp();
    thresh = 1;
    send(8'h57, 0);  expect3("R5 below floor", 1, 0, 0);
    send(8'h0F, 0);  expect3("R5 at floor", 4, 1, 1);
    idle(1);
  endtask

  task automatic t_scale();
    thresh = 4; scale_sel = 2;
    send(8'h00, 0);  expect3("R6 x4 below", 12, 0, 0);
    send(8'h00, 0);  expect3("R6 x4 reached", 20, 1, 1);
    scale_sel = 3;
    send(8'h00, 0);  expect3("R6 x8 below", 28, 0, 1);
    send(8'h00, 0);  expect3("R6 x8 reached", 36, 1, 1);
  endtask

  task automatic t_saturate();
    send(8'h00, 0);  chk("R7 run 44", run_len, 44);
    send(8'h00, 0);  chk("R7 run 52", run_len, 52);
    send(8'h00, 0);  chk("R7 run 60", run_len, 60);
    send(8'h00, 0);  expect3("R7 saturate", 63, 1, 1);
    send(8'h00, 0);  expect3("R7 hold at max", 63, 1, 1);
  endtask

  task automatic t_clear_priority();
    send(8'h00, 1);  expect3("R9 violation beats clear", 63, 1, 1);
    send(8'hFF, 1);  expect3("R9 clear with clean word", 8, 0, 0);
  endtask

  task automatic t_x2_after_reset();
    do_reset();
    thresh = 5; scale_sel = 1;
    send(8'hFF, 0);  expect3("R1 R6 x2 first word", 8, 0, 0);
    send(8'h03, 0);  expect3("R6 x2 reached", 6, 1, 1);
  endtask

  initial begin
    #(CLK_T * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    t_runs_carry();
    t_idle_clear();
    t_clamp();
    t_scale();
    t_saturate();
    t_clear_priority();
    t_x2_after_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule